// File: doc/BRIEF.md
# SDRAM Refresh Scheduler with Priority Escalation

This block decides when the memory controller owes its SDRAM devices a refresh, and then carries out that refresh. A prescaler divides the controller clock. An interval counter divides it further. Each expiry of the interval counter raises a refresh request toward the controller's arbiter.

The request starts at low priority. A low-priority request is offered only when the controller is idle and no other memory request is waiting. If the interval expires twice more while the request is still unserved, the request becomes urgent. An urgent request is offered as soon as the controller finishes its current operation, whatever else is waiting.

Once the arbiter grants the request, the block does not refresh every device at once. It issues AUTO-REFRESH to one device per clock, lowest index first, which spreads the current draw over several cycles. After a device has been refreshed, a per-device lockout keeps ACTIVATE away from that device for a programmed number of clocks. Expiries that arrive while a refresh is still in progress are kept and start a fresh low-priority request.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, all of these outputs are 0: `ref_req`, `ref_high`, `ref_busy`, `ar_fire`, `ar_dev` and `act_block`. Asserting reset clears them at once, without waiting for a clock edge.
- R2: The interval expires once every (`cfg_prescale`+1)×(`cfg_interval`+1) clocks. The first expiry with no request pending raises a request at low priority (`ref_high`=0).
- R3: A low-priority request appears on `ref_req` only in a cycle where `mem_idle`=1 and `other_req`=0.
- R4: A pending request that has not been accepted becomes high priority (`ref_high`=1) at its second further expiry. From its first appearance on `ref_req` to `ref_high` therefore takes 2×(`cfg_prescale`+1)×(`cfg_interval`+1) clocks. It stays high until the request is accepted.
- R5: A high-priority request appears on `ref_req` whenever `mem_idle`=1 and no refresh sequence is running, even while `other_req`=1. It is withdrawn while `mem_idle`=0.
- R6: A grant is accepted only when `ref_grant` and `ref_req` are both 1 in the same cycle. A grant given while `ref_req`=0 has no effect. Acceptance clears the pending request and its priority.
- R7: In the cycle after acceptance, `ref_busy` and `ar_fire` are 1 for exactly NUM_DEV cycles. In cycle k of that run, `ar_dev` is one-hot with bit k set, where bit i stands for device i. After the run, both `ar_fire` and `ar_dev` are 0.
- R8: `act_block[i]` is 1 for exactly `cfg_recovery` cycles, starting in the cycle after device i's AUTO-REFRESH. With `cfg_recovery`=0, it never rises.
- R9: An expiry that occurs during a refresh sequence leaves a new low-priority request pending. That request appears on `ref_req` in the first cycle after the sequence ends.
- R10: `ref_req` is 0 in every cycle where `ref_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_prescale | input | PRE_W | Prescaler terminal count; divides the clock by value+1 |
| cfg_interval | input | INT_W | Interval terminal count, in prescaled ticks; divides by value+1 |
| cfg_recovery | input | RCV_W | ACTIVATE lockout length, in clocks, after a device's refresh |
| mem_idle | input | 1 | Controller has no memory operation in progress |
| other_req | input | 1 | Some other memory request is waiting at the arbiter |
| ref_grant | input | 1 | Arbiter grants the refresh request |
| ref_req | output | 1 | Refresh request offered to the arbiter |
| ref_high | output | 1 | Pending request has been promoted to high priority |
| ref_busy | output | 1 | Refresh sequence in progress |
| ar_fire | output | 1 | Issue AUTO-REFRESH this cycle |
| ar_dev | output | NUM_DEV | One-hot target device for `ar_fire` |
| act_block | output | NUM_DEV | Per-device ACTIVATE lockout |

## Verification
The hardest situation to reach from the ports is an interval expiry that falls inside the short refresh sequence. That expiry must be kept as a new request, and it must neither be lost nor escalate on its own.

The bench reaches it with a period of three clocks. It issues the grant in the cycle right after `ref_high` rises, which is also the cycle right after an expiry. This pins the next expiry to the middle of the four-cycle sequence. The bench then checks that the first idle cycle shows a low-priority request.

Escalation under a steady stream of competing traffic is reached by holding `other_req` high until the request turns urgent.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  // Number of interval expiries missed since the request was raised.
  typedef enum logic [1:0] {
    MISS_NONE = 2'd0,
    MISS_ONE  = 2'd1,
    MISS_TWO  = 2'd2
  } rfs_miss_e;
endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
  parameter int PRE_W = 8,
  parameter int INT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic [INT_W-1:0] cfg_interval,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [INT_W-1:0] ivl_q, ivl_d;
  logic             pre_wrap, ivl_wrap;

  // >= instead of == so that lowering the config mid-count cannot strand the counters.
  assign pre_wrap = (pre_q >= cfg_prescale);
  assign ivl_wrap = (ivl_q >= cfg_interval);
  assign tick     = pre_wrap && ivl_wrap;

  always_comb begin
    pre_d = pre_wrap ? '0 : pre_q + 1'b1;
    ivl_d = ivl_q;
    if (pre_wrap) begin
      ivl_d = ivl_wrap ? '0 : ivl_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ivl_q <= '0;
    end else begin
      pre_q <= pre_d;
      ivl_q <= ivl_d;
    end
  end
endmodule

// File: rtl/rfs_escalate.sv
module rfs_escalate
  import rfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic accept,
  output logic pending,
  output logic urgent
);
  logic      pend_q, pend_d;
  rfs_miss_e miss_q, miss_d;

  always_comb begin
    pend_d = pend_q;
    miss_d = miss_q;
    if (accept) begin
      // An expiry in the accepting cycle immediately opens the next request.
      pend_d = tick;
      miss_d = MISS_NONE;
    end else if (tick) begin
      if (!pend_q) begin
        pend_d = 1'b1;
        miss_d = MISS_NONE;
      end else begin
        miss_d = (miss_q == MISS_NONE) ? MISS_ONE : MISS_TWO;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      miss_q <= MISS_NONE;
    end else begin
      pend_q <= pend_d;
      miss_q <= miss_d;
    end
  end

  assign pending = pend_q;
  assign urgent  = pend_q && (miss_q == MISS_TWO);
endmodule

// File: rtl/rfs_stagger.sv
module rfs_stagger #(
  parameter int NUM_DEV = 4,
  parameter int RCV_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [RCV_W-1:0]   cfg_recovery,
  output logic               busy,
  output logic               ar_fire,
  output logic [NUM_DEV-1:0] ar_dev,
  output logic [NUM_DEV-1:0] act_block
);
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DEV - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             at_last;

  assign at_last = (idx_q == LAST_IDX);

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      busy_d = !at_last;
      idx_d  = at_last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign busy    = busy_q;
  assign ar_fire = busy_q;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    logic [RCV_W-1:0] cnt_q, cnt_d;
    logic             hit;

    assign hit = busy_q && (idx_q == IDX_W'(i));

    always_comb begin
      cnt_d = cnt_q;
      if (hit) begin
        cnt_d = cfg_recovery;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_d;
      end
    end

    assign ar_dev[i]    = hit;
    assign act_block[i] = (cnt_q != '0);
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int NUM_DEV = 4,
  parameter int PRE_W   = 8,
  parameter int INT_W   = 12,
  parameter int RCV_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRE_W-1:0]   cfg_prescale,
  input  logic [INT_W-1:0]   cfg_interval,
  input  logic [RCV_W-1:0]   cfg_recovery,
  input  logic               mem_idle,
  input  logic               other_req,
  input  logic               ref_grant,
  output logic               ref_req,
  output logic               ref_high,
  output logic               ref_busy,
  output logic               ar_fire,
  output logic [NUM_DEV-1:0] ar_dev,
  output logic [NUM_DEV-1:0] act_block
);
  localparam int SYNC_LEN = 2;

  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_int_n;
  logic                tick, pending, urgent, busy, accept;

  // Reset asserts asynchronously and deasserts after SYNC_LEN clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_LEN-1];

  rfs_tick_gen #(.PRE_W(PRE_W), .INT_W(INT_W)) u_tick (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cfg_prescale (cfg_prescale),
    .cfg_interval (cfg_interval),
    .tick         (tick)
  );

  rfs_escalate u_esc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .accept  (accept),
    .pending (pending),
    .urgent  (urgent)
  );

  rfs_stagger #(.NUM_DEV(NUM_DEV), .RCV_W(RCV_W)) u_stag (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .accept       (accept),
    .cfg_recovery (cfg_recovery),
    .busy         (busy),
    .ar_fire      (ar_fire),
    .ar_dev       (ar_dev),
    .act_block    (act_block)
  );

  // Low priority yields to any other traffic; high priority only waits for idle.
  assign ref_req  = pending && !busy && mem_idle && (urgent || !other_req);
  assign ref_high = urgent;
  assign ref_busy = busy;
  assign accept   = ref_grant && ref_req;
endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk #(
  parameter int NUM_DEV = 4,
  parameter int RCV_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [RCV_W-1:0]   cfg_recovery,
  input logic               mem_idle,
  input logic               other_req,
  input logic               ref_grant,
  input logic               ref_req,
  input logic               ref_high,
  input logic               ref_busy,
  input logic               ar_fire,
  input logic [NUM_DEV-1:0] ar_dev
  ,
  input logic [NUM_DEV-1:0] act_block
);
  // R3
  low_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_high) |-> (mem_idle && !other_req));

  // R5
  high_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_high && mem_idle && !ref_busy) |-> ref_req);

  // R6
  stray_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_grant && !ref_req && !ref_busy) |=> !ref_busy);

  // R7
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |-> $onehot(ar_dev));

  // R7
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_fire && !ar_dev[NUM_DEV-1]) |=> (ar_fire && (ar_dev == ($past(ar_dev) << 1))));

  // R7
  seq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_fire && ar_dev[NUM_DEV-1]) |=> (!ref_busy && !ar_fire));

  // R10
  no_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !ref_req);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_lock
    // R8
    lock_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_dev[i] && (cfg_recovery != '0)) |=> act_block[i]);
    // R8
    lock_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_dev[i] && (cfg_recovery == '0)) |=> !act_block[i]);
  end
endmodule

bind sdram_refresh_sched rfs_sched_chk #(.NUM_DEV(NUM_DEV), .RCV_W(RCV_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_recovery (cfg_recovery),
  .mem_idle     (mem_idle),
  .other_req    (other_req),
  .ref_grant    (ref_grant),
  .ref_req      (ref_req),
  .ref_high     (ref_high),
  .ref_busy     (ref_busy),
  .ar_fire      (ar_fire),
  .ar_dev       (ar_dev),
  .act_block    (act_block)
);

// File: tb/sdram_refresh_sched_bench.sv
module sdram_refresh_sched_bench;
  localparam int N     = 4;
  localparam int PRE_W = 8;
  localparam int INT_W = 12;
  localparam int RCV_W = 6;
  localparam int WDOG  = 100000;
  localparam int NVEC  = 5;
  // Each row: prescale, interval, recovery
  localparam int VEC [0:NVEC-1][0:2] = '{
    '{0, 0, 0},
    '{1, 3, 2},
    '{2, 4, 5},
    '{3, 1, 3},
    '{0, 5, 1}
  };

  logic             clk;
  logic             rst_n;
  logic [PRE_W-1:0] cfg_prescale;
  logic [INT_W-1:0] cfg_interval;
  logic [RCV_W-1:0] cfg_recovery;
  logic             mem_idle, other_req, ref_grant;
  logic             ref_req, ref_high, ref_busy, ar_fire;
  logic [N-1:0]     ar_dev, act_block;

  int n_chk;
  int n_bad;

  sdram_refresh_sched #(.NUM_DEV(N), .PRE_W(PRE_W), .INT_W(INT_W), .RCV_W(RCV_W)) u_sdram_refresh_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_prescale (cfg_prescale),
    .cfg_interval (cfg_interval),
    .cfg_recovery (cfg_recovery),
    .mem_idle     (mem_idle),
    .other_req    (other_req),
    .ref_grant    (ref_grant),
    .ref_req      (ref_req),
    .ref_high     (ref_high),
    .ref_busy     (ref_busy),
    .ar_fire      (ar_fire),
    .ar_dev       (ar_dev),
    .act_block    (act_block)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset(input int p, input int i, input int r);
    @(negedge clk);
    rst_n = 1'b0;
    ref_grant = 1'b0;
    cfg_prescale = PRE_W'(p);
    cfg_interval = INT_W'(i);
    cfg_recovery = RCV_W'(r);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Waits at falling edges until ref_high is 1; returns the number of cycles waited.
  task automatic wait_high(output int cyc);
    cyc = 0;
    while (!ref_high && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", WDOG, WDOG);
    finish_run();
  end

  initial begin
    int cyc;
    int guard;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    mem_idle = 1'b1;
    other_req = 1'b0;
    ref_grant = 1'b0;
    cfg_prescale = '0;
    cfg_interval = '0;
    cfg_recovery = '0;

    // R1: every output is quiet while reset is held.
    repeat (3) @(negedge clk);
    chk({ref_req, ref_high, ref_busy, ar_fire, ar_dev, act_block} == '0,
        "R1 outputs in reset", int'({ar_dev, act_block}), 0);

    // Table walk: check the escalation delay, the staggered sequence and the lockouts.
    for (int v = 0; v < NVEC; v++) begin
      int p;
      int iv;
      int r;
      int per;
      p = VEC[v][0];
      iv = VEC[v][1];
      r = VEC[v][2];
      per = (p + 1) * (iv + 1);
      do_reset(p, iv, r);
      guard = 0;
      while (!ref_req && guard < 5000) begin
        @(negedge clk);
        guard++;
      end
      chk(ref_req && !ref_high, "R2 first expiry raises a low request", int'(ref_high), 0);
      wait_high(cyc);
      chk(cyc == 2 * per, "R4 R2 cycles until escalation", cyc, 2 * per);
      ref_grant = 1'b1;
      @(negedge clk);
      ref_grant = 1'b0;
      for (int c = 0; c <= N + r + 1; c++) begin
        logic [N-1:0] exp_dev;
        logic [N-1:0] exp_blk;
        exp_dev = (c < N) ? N'(1 << c) : '0;
        for (int d = 0; d < N; d++) begin
          exp_blk[d] = (d < c) && ((c - d) <= r);
        end
        chk(ar_dev == exp_dev && ar_fire == (c < N) && ref_busy == (c < N),
            "R7 staggered refresh order", int'(ar_dev), int'(exp_dev));
        chk(act_block == exp_blk, "R8 activate lockout", int'(act_block), int'(exp_blk));
        if (c < N) begin
          chk(!ref_req, "R10 no request while busy", int'(ref_req), 0);
        end
        @(negedge clk);
      end
    end

    // R3, R5, R4, R6: hold competing traffic until the request turns urgent.
    do_reset(0, 9, 2);
    other_req = 1'b1;
    mem_idle = 1'b1;
    cyc = 0;
    guard = 0;
    while (!ref_high && guard < 5000) begin
      if (ref_req) begin
        cyc++;
      end
      @(negedge clk);
      guard++;
    end
    chk(cyc == 0, "R3 low request held back by other traffic", cyc, 0);
    chk(ref_req == 1'b1, "R5 urgent request offered despite other traffic", int'(ref_req), 1);
    mem_idle = 1'b0;
    #1;
    chk(ref_req == 1'b0, "R5 urgent request waits for idle", int'(ref_req), 0);
    repeat (25) @(negedge clk);
    chk(ref_high == 1'b1, "R4 priority stays high", int'(ref_high), 1);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    chk(!ref_busy && !ar_fire, "R6 grant without request ignored", int'(ref_busy), 0);
    mem_idle = 1'b1;
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    chk(ref_busy == 1'b1, "R6 grant accepted", int'(ref_busy), 1);
    chk(ref_high == 1'b0, "R6 acceptance clears priority", int'(ref_high), 0);
    other_req = 1'b0;

    // R9: with a three-cycle period, an expiry falls inside the sequence.
    do_reset(0, 2, 1);
    wait_high(cyc);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    repeat (4) @(negedge clk);
    chk(!ref_busy && ref_req && !ref_high, "R9 expiry during sequence kept as low request",
        int'({ref_busy, ref_req, ref_high}), 3'b010);

    // R1: reset in the middle of activity clears outputs immediately.
    rst_n = 1'b0;
    #1;
    chk({ref_req, ref_high, ref_busy, ar_fire, ar_dev, act_block} == '0,
        "R1 asynchronous clear", int'({ref_req, ref_busy}), 0);

    finish_run();
  end
endmodule